// File: doc/BRIEF.md
# Clocked Serial Transceiver with Ready Handshake

This block moves bytes over a synchronous four-wire serial link: one data line in, one data line out, an active-low shift clock, and an active-low ready line. One instance can act as the clock master or as the clock slave. The master makes its shift clock from a prescaler and an 8-bit reload timer. Each timer underflow toggles the clock line, so the clock always has a 50% duty cycle. The slave takes its clock from the pin and uses the ready line to tell the master it has a byte loaded or room to receive one.

Software-side control is a small configuration word plus two enables. The configuration word holds a role code, a line-coding code and the timer reload value. The enables are one for transmit and one for receive. Bytes go in through a one-entry transmit buffer. They come out through a receive register that updates together with a one-cycle completion pulse. Data goes least significant bit first in both directions. A bit is driven on the falling clock edge and sampled on the rising edge.

Top module: `syncser_xcvr`

## Requirements
- R1: After reset the shift clock output, the ready output and the serial data output are all high, and `busy`, `xfer_done`, `tx_pend` and `rx_data` are all zero.
- R2: After reset the line-coding field holds the non-plain code 11, and the block stays idle until code 00 is written. A master with a byte pending and ready held low does not start while the field is not 00.
- R3: A configuration write (role, line coding, reload) takes effect only when `tx_en` and `rx_en` are both 0. A write made while either enable is 1 leaves the configuration unchanged.
- R4: Role code 00 selects master, and the master drives the shift clock (`sclk_oe` = 1). Role code 01 selects slave, and the slave takes the clock from `sclk_n_i` (`sclk_oe` = 0).
- R5: In master mode each clock half-period lasts (reload + 1) × PRE_DIV clock cycles, so consecutive falling edges of the shift clock are 2 × (reload + 1) × PRE_DIV cycles apart.
- R6: A master with a byte pending starts only while `rdy_n_i` is low. While ready stays high the shift clock stays high and `busy` stays 0.
- R7: Each byte is shifted least significant bit first, with output bits changed on falling edges and input bits sampled on rising edges. A master-slave pair exchanges both bytes intact.
- R8: A slave pulls `rdy_n_o` low when it is enabled with a byte loaded in transmit, or enabled for receive only. In the receive-only case it sends all ones. It releases `rdy_n_o` high after the 8th bit.
- R9: The shift clock idles high between bytes. After each byte the master holds it high for at least one half-period before the next byte starts.
- R10: `xfer_done` is high for exactly one cycle per byte. `rx_data` changes only in that cycle, and only when `rx_en` is 1.
- R11: `tx_load` captures `tx_data` only while `tx_en` is 1 and the buffer is empty, and sets `tx_pend`. A load made while `tx_pend` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_xfer_mode | input | 2 | Role code: 00 master, 01 slave |
| cfg_line_mode | input | 2 | Line coding: 00 plain |
| cfg_reload | input | TMR_W | Reload value of the clock timer |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tx_load | input | 1 | Load strobe for the transmit buffer |
| tx_data | input | DATA_W | Byte to transmit |
| tx_pend | output | 1 | Transmit buffer holds a byte |
| rx_data | output | DATA_W | Last received byte |
| xfer_done | output | 1 | One-cycle pulse at the end of a byte |
| busy | output | 1 | Transfer or post-byte gap in progress |
| sin_i | input | 1 | Serial data in |
| sout_o | output | 1 | Serial data out |
| sclk_n_i | input | 1 | Shift clock from the pin (slave) |
| sclk_n_o | output | 1 | Shift clock driven (master) |
| sclk_oe | output | 1 | Shift clock output enable |
| rdy_n_i | input | 1 | Ready from the peer (master) |
| rdy_n_o | output | 1 | Ready to the peer (slave) |

## Verification
The bench builds a master instance and a slave instance, both with PRE_DIV = 2 and 8-bit data and timer widths, and wires them back to back. It uses reload values 3 and 5. These give half-periods of 8 and 12 cycles, which leaves room for the two-stage pin synchronizers and the ready round trip. They also give two clearly different falling-edge spacings to measure. The small prescaler keeps every byte under a couple of hundred cycles. That leaves room in the run for long stall windows, ignored loads and writes, and the receive-only slave.

// File: rtl/syncser_pkg.sv
package syncser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } xfer_state_e;

    localparam logic [1:0] ROLE_MASTER = 2'b00;
    localparam logic [1:0] ROLE_SLAVE  = 2'b01;
    localparam logic [1:0] LINE_PLAIN  = 2'b00;
    localparam logic [1:0] LINE_RESET  = 2'b11;

endpackage

// File: rtl/syncser_sync.sv
module syncser_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= RST_VAL;
            end else if (g == 0) begin
                stg_q[g] <= d_i;
            end else begin
                stg_q[g] <= stg_q[(g > 0) ? g - 1 : 0];
            end
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/syncser_tick_gen.sv
module syncser_tick_gen #(
    parameter int TMR_W   = 8,
    parameter int PRE_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [TMR_W-1:0] reload,
    output logic             toggle
);
    localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    typedef struct packed {
        logic [PW-1:0]    pre;
        logic [TMR_W-1:0] tmr;
    } tick_t;

    tick_t t_d, t_q;
    logic  pre_tick;

    always_comb begin
        t_d      = t_q;
        pre_tick = (t_q.pre == PW'(PRE_DIV - 1));
        toggle   = run && pre_tick && (t_q.tmr == '0);
        if (!run) begin
            t_d.pre = '0;
            t_d.tmr = reload;
        end else begin
            t_d.pre = pre_tick ? '0 : t_q.pre + 1'b1;
            if (pre_tick) begin
                t_d.tmr = (t_q.tmr == '0) ? reload : t_q.tmr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/syncser_xcvr.sv
module syncser_xcvr
    import syncser_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TMR_W   = 8,
    parameter int PRE_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_xfer_mode,
    input  logic [1:0]        cfg_line_mode,
    input  logic [TMR_W-1:0]  cfg_reload,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pend,
    output logic [DATA_W-1:0] rx_data,
    output logic              xfer_done,
    output logic              busy,
    input  logic              sin_i,
    output logic              sout_o,
    input  logic              sclk_n_i,
    output logic              sclk_n_o,
    output logic              sclk_oe,
    input  logic              rdy_n_i,
    output logic              rdy_n_o
);
    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int FW = 4 + TMR_W;

    typedef struct packed {
        xfer_state_e       st;
        logic [1:0]        xfer;
        logic [1:0]        line;
        logic [TMR_W-1:0]  reload;
        logic [DATA_W-1:0] txbuf;
        logic              txfull;
        logic [DATA_W-1:0] sh;
        logic [CW-1:0]     cnt;
        logic              sclk;
        logic              sclk_prev;
        logic              sout;
        logic [DATA_W-1:0] rx;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]    pins_s;
    logic          rdy_s, sclk_s, sin_s;
    logic          is_master, is_slave, tog, run_tmr;
    logic          fall_e, rise_e;
    logic [FW-1:0] cfg_flat;

    syncser_sync #(.W(3), .STAGES(2), .RST_VAL(3'b111)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({rdy_n_i, sclk_n_i, sin_i}),
        .q_o   (pins_s)
    );
    assign {rdy_s, sclk_s, sin_s} = pins_s;

    assign is_master = (r_q.xfer == ROLE_MASTER) && (r_q.line == LINE_PLAIN);
    assign is_slave  = (r_q.xfer == ROLE_SLAVE)  && (r_q.line == LINE_PLAIN);
    assign run_tmr   = is_master && (r_q.st != ST_IDLE);
    assign cfg_flat  = {r_q.xfer, r_q.line, r_q.reload};

    syncser_tick_gen #(.TMR_W(TMR_W), .PRE_DIV(PRE_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_tmr),
        .reload (r_q.reload),
        .toggle (tog)
    );

    always_comb begin
        r_d           = r_q;
        r_d.done      = 1'b0;
        r_d.sclk_prev = sclk_s;
        fall_e        = 1'b0;
        rise_e        = 1'b0;

        if (cfg_we && !tx_en && !rx_en) begin
            r_d.xfer   = cfg_xfer_mode;
            r_d.line   = cfg_line_mode;
            r_d.reload = cfg_reload;
        end
        if (tx_load && tx_en && !r_q.txfull) begin
            r_d.txbuf  = tx_data;
            r_d.txfull = 1'b1;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                r_d.sclk = 1'b1;
                if (is_master && tx_en && r_q.txfull && !rdy_s) begin
                    r_d.st     = ST_SHIFT;
                    r_d.sh     = r_q.txbuf;
                    r_d.txfull = 1'b0;
                    r_d.cnt    = '0;
                end else if (is_slave && ((tx_en && r_q.txfull) || (rx_en && !tx_en))) begin
                    r_d.st     = ST_SHIFT;
                    r_d.sh     = (tx_en && r_q.txfull) ? r_q.txbuf : '1;
                    r_d.txfull = r_q.txfull && !tx_en;
                    r_d.cnt    = '0;
                end
            end
            ST_SHIFT: begin
                if (is_master) begin
                    if (tog) r_d.sclk = ~r_q.sclk;
                    fall_e = tog && r_q.sclk;
                    rise_e = tog && !r_q.sclk;
                end else begin
                    fall_e = r_q.sclk_prev && !sclk_s;
                    rise_e = !r_q.sclk_prev && sclk_s;
                end
                if (fall_e) begin
                    r_d.sout = r_q.sh[0];
                end
                if (rise_e) begin
                    r_d.sh  = {sin_s, r_q.sh[DATA_W-1:1]};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CW'(DATA_W - 1)) begin
                        r_d.done = 1'b1;
                        if (rx_en) r_d.rx = {sin_s, r_q.sh[DATA_W-1:1]};
                        r_d.st   = is_master ? ST_GAP : ST_IDLE;
                    end
                end
            end
            ST_GAP: begin
                if (tog) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= ST_IDLE;
            r_q.line      <= LINE_RESET;
            r_q.sclk      <= 1'b1;
            r_q.sclk_prev <= 1'b1;
            r_q.sout      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_pend   = r_q.txfull;
    assign rx_data   = r_q.rx;
    assign xfer_done = r_q.done;
    assign busy      = (r_q.st != ST_IDLE);
    assign sout_o    = r_q.sout;
    assign sclk_n_o  = r_q.sclk;
    assign sclk_oe   = (r_q.xfer == ROLE_MASTER);
    assign rdy_n_o   = !(is_slave && (r_q.st == ST_SHIFT));
endmodule

// File: rtl/syncser_xcvr_chk.sv
module syncser_xcvr_chk #(
    parameter int DATA_W = 8,
    parameter int FW     = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_en,
    input logic              rx_en,
    input logic              busy,
    input logic              xfer_done,
    input logic              sclk_n_o,
    input logic              rdy_n_o,
    input logic [DATA_W-1:0] rx_data,
    input logic [FW-1:0]     cfg_flat,
    input logic              rdy_s,
    input logic              is_master
);
    a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en || rx_en) |=> $stable(cfg_flat));

    a_r6_start_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && is_master) |-> !$past(rdy_s));

    a_r9_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sclk_n_o);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r10_rx_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_done |-> $stable(rx_data));

    a_r8_ready_release: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !is_master) |-> rdy_n_o);
endmodule

bind syncser_xcvr syncser_xcvr_chk #(.DATA_W(DATA_W), .FW(FW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .rx_en     (rx_en),
    .busy      (busy),
    .xfer_done (xfer_done),
    .sclk_n_o  (sclk_n_o),
    .rdy_n_o   (rdy_n_o),
    .rx_data   (rx_data),
    .cfg_flat  (cfg_flat),
    .rdy_s     (rdy_s),
    .is_master (is_master)
);

// File: tb/test_syncser_xcvr.sv
module test_syncser_xcvr;
    localparam int DW  = 8;
    localparam int TW  = 8;
    localparam int PRE = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic          m_we = 0, s_we = 0;
    logic [1:0]    m_xm = 0, m_lm = 0, s_xm = 0, s_lm = 0;
    logic [TW-1:0] m_rl = 0, s_rl = 0;
    logic          m_txen = 0, m_rxen = 0, s_txen = 0, s_rxen = 0;
    logic          m_ld = 0, s_ld = 0;
    logic [DW-1:0] m_td = 0, s_td = 0;
    logic          m_pend, s_pend, m_done, s_done, m_busy, s_busy;
    logic [DW-1:0] m_rx, s_rx;
    logic          m_sout, s_sout, m_sclk, s_sclk, m_oe, s_oe, m_rdy, s_rdy;

    syncser_xcvr #(.DATA_W(DW), .TMR_W(TW), .PRE_DIV(PRE)) i_syncser_xcvr (
        .clk(clk), .rst_n(rst_n), .cfg_we(m_we), .cfg_xfer_mode(m_xm),
        .cfg_line_mode(m_lm), .cfg_reload(m_rl), .tx_en(m_txen), .rx_en(m_rxen),
        .tx_load(m_ld), .tx_data(m_td), .tx_pend(m_pend), .rx_data(m_rx),
        .xfer_done(m_done), .busy(m_busy), .sin_i(s_sout), .sout_o(m_sout),
        .sclk_n_i(1'b1), .sclk_n_o(m_sclk), .sclk_oe(m_oe),
        .rdy_n_i(s_rdy), .rdy_n_o(m_rdy));

    syncser_xcvr #(.DATA_W(DW), .TMR_W(TW), .PRE_DIV(PRE)) i_slave (
        .clk(clk), .rst_n(rst_n), .cfg_we(s_we), .cfg_xfer_mode(s_xm),
        .cfg_line_mode(s_lm), .cfg_reload(s_rl), .tx_en(s_txen), .rx_en(s_rxen),
        .tx_load(s_ld), .tx_data(s_td), .tx_pend(s_pend), .rx_data(s_rx),
        .xfer_done(s_done), .busy(s_busy), .sin_i(m_sout), .sout_o(s_sout),
        .sclk_n_i(m_sclk), .sclk_n_o(s_sclk), .sclk_oe(s_oe),
        .rdy_n_i(1'b1), .rdy_n_o(s_rdy));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard
    logic [DW-1:0] exp_m[$];
    logic [DW-1:0] exp_s[$];
    int m_cnt = 0, s_cnt = 0;
    int exp_period = 0;
    logic m_done_prev = 0;

    always @(negedge clk) begin
        if (rst_n && m_done) begin
            m_cnt++;
            check(m_sclk == 1'b1, "R9 clock high at byte end", m_sclk, 1);
            if (exp_m.size() == 0) check(0, "R7 unexpected master byte", m_rx, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_m.pop_front();
                check(m_rx == e, "R7/R10 master rx byte", m_rx, e);
            end
        end
        if (rst_n && m_done_prev) check(!m_done, "R10 done one cycle", m_done, 0);
        m_done_prev <= m_done;
        if (rst_n && s_done) begin
            s_cnt++;
            if (exp_s.size() == 0) check(0, "R7 unexpected slave byte", s_rx, 0);
            else begin
                logic [DW-1:0] e;
                e = exp_s.pop_front();
                check(s_rx == e, "R7 slave rx byte", s_rx, e);
            end
        end
    end

    // clock period monitor
    logic prev_sclk = 1'b1;
    bit   have_fall = 0;
    int   last_fall = 0;
    always @(negedge clk) begin
        if (rst_n && m_busy && prev_sclk && !m_sclk) begin
            if (have_fall) check(cyc - last_fall == exp_period, "R5 clock period",
                                 cyc - last_fall, exp_period);
            last_fall = cyc;
            have_fall = 1;
        end
        if (!m_busy) have_fall = 0;
        prev_sclk = m_sclk;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic m_cfg(input logic [1:0] xm, input logic [1:0] lm, input logic [TW-1:0] rl);
        m_xm = xm; m_lm = lm; m_rl = rl; m_we = 1; tick(1); m_we = 0;
    endtask

    task automatic s_cfg(input logic [1:0] xm, input logic [1:0] lm, input logic [TW-1:0] rl);
        s_xm = xm; s_lm = lm; s_rl = rl; s_we = 1; tick(1); s_we = 0;
    endtask

    task automatic m_load(input logic [DW-1:0] d);
        m_td = d; m_ld = 1; tick(1); m_ld = 0;
    endtask

    task automatic s_load(input logic [DW-1:0] d);
        s_td = d; s_ld = 1; tick(1); s_ld = 0;
    endtask

    task automatic wait_counts(input int mt, input int st);
        int t = 0;
        while ((m_cnt < mt || s_cnt < st) && t < 5000) begin tick(1); t++; end
        check(t < 5000, "R7 transfer completes", m_cnt, mt);
        tick(4);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        @(negedge clk);
        // R1 reset state
        check(m_sclk && m_rdy && m_sout, "R1 lines high", {m_sclk, m_rdy, m_sout}, 3'b111);
        check(!m_busy && !m_done && !m_pend && m_rx == 0, "R1 status zero",
              {m_busy, m_done, m_pend, m_rx}, 0);
        tick(1);

        m_cfg(2'b00, 2'b01, 8'd3);   // master role, non-plain line code
        s_cfg(2'b01, 2'b00, 8'd3);
        exp_period = 2 * (3 + 1) * PRE;
        @(negedge clk);
        check(m_oe == 1'b1, "R4 master drives clock", m_oe, 1);
        check(s_oe == 1'b0, "R4 slave takes clock", s_oe, 0);
        tick(1);

        m_txen = 1; m_rxen = 1; s_txen = 1; s_rxen = 1;
        m_load(8'hA5);
        s_load(8'h3C);
        tick(10);
        @(negedge clk);
        check(s_rdy == 1'b0, "R8 slave ready low when loaded", s_rdy, 0);
        tick(200);
        @(negedge clk);
        check(!m_busy && m_sclk, "R2 idle without plain line code", {m_busy, m_sclk}, 2'b01);

        // R3 write while enabled is ignored
        m_cfg(2'b00, 2'b00, 8'd3);
        tick(200);
        @(negedge clk);
        check(!m_busy && m_sclk && m_pend, "R3 write ignored while enabled",
              {m_busy, m_sclk, m_pend}, 3'b011);
        tick(1);

        // enable properly: transfer A5 <-> 3C
        m_txen = 0; m_rxen = 0;
        m_cfg(2'b00, 2'b00, 8'd3);
        exp_m.push_back(8'h3C);
        exp_s.push_back(8'hA5);
        m_txen = 1; m_rxen = 1;
        wait_counts(1, 1);
        @(negedge clk);
        check(s_rdy == 1'b1, "R8 slave ready released after byte", s_rdy, 1);
        tick(1);

        // R11 second load ignored, R6 stall while ready high
        m_load(8'h11);
        m_load(8'h22);
        tick(300);
        @(negedge clk);
        check(!m_busy && m_sclk && m_pend, "R6 stall while ready high",
              {m_busy, m_sclk, m_pend}, 3'b011);
        tick(1);
        exp_m.push_back(8'h99);
        exp_s.push_back(8'h11);
        s_load(8'h99);
        wait_counts(2, 2);
        @(negedge clk);
        check(!m_pend, "R11 buffer empty after byte (second load dropped)", m_pend, 0);
        tick(1);

        // R10 master receive disabled: rx_data unchanged
        m_rxen = 0;
        exp_m.push_back(8'h99);
        exp_s.push_back(8'hC3);
        s_load(8'h5A);
        m_load(8'hC3);
        wait_counts(3, 3);
        @(negedge clk);
        check(m_rx == 8'h99, "R10 rx held when receive off", m_rx, 8'h99);
        tick(1);

        // R8 receive-only slave sends all ones
        m_rxen = 1;
        s_txen = 0;
        tick(8);
        @(negedge clk);
        check(s_rdy == 1'b0, "R8 receive-only slave ready", s_rdy, 0);
        tick(1);
        exp_m.push_back(8'hFF);
        exp_s.push_back(8'h0F);
        m_load(8'h0F);
        wait_counts(4, 4);

        // R5 different reload; slave re-armed receive-only with all ones
        m_txen = 0; m_rxen = 0;
        m_cfg(2'b00, 2'b00, 8'd5);
        exp_period = 2 * (5 + 1) * PRE;
        m_txen = 1; m_rxen = 1;
        exp_m.push_back(8'hFF);
        exp_s.push_back(8'hE7);
        m_load(8'hE7);
        wait_counts(5, 5);

        check(exp_m.size() == 0 && exp_s.size() == 0, "R7 scoreboard drained",
              exp_m.size() + exp_s.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule